// File: doc/BRIEF.md
# Serial LED Matrix Display Host Writer

This block is the host-side master for a chain of 4-character LED dot-matrix drivers. The drivers are chained through their serial data pins and share a common select line, chip-enable, serial clock and reset. The block runs on a fast system clock and builds the slow serial waveforms from it. After a system reset it pulses the display reset line and then brings the chain out of sleep with a fixed sequence. First it loads an all-dark dot frame. Then it writes brightness control word 0 with the wake bit set.

After start-up the host posts requests on a valid/ready handshake. A frame request shifts a full dot frame into the chain. The dots come from a one-bit valid/ready stream. The first dot taken is row 0 of column 0 of the left-most character. A control request shifts one 8-bit control byte, MSB first. The byte is repeated once per device when the chain is in serial data-out mode, and sent once in simultaneous mode. Each transfer has the same shape:

1. Select drives the register choice.
2. Chip-enable goes low.
3. The bits are clocked in.
4. Chip-enable returns high while the serial clock is high.
5. The serial clock falls, which latches the data.
6. A recovery half-period follows before the next request is taken.

Top module: `disp_host_ctrl`

## Requirements
- R1: During system reset and for exactly RST_CYC system cycles after it is released, `disp_rst_n` is low (64 ns at defaults). During that time `disp_ce_n` is high, `disp_clk` is low, and `req_ready` and `bit_ready` are low.
- R2: After the reset pulse, the block first sends a frame of DOTS_PER_DEV×N zero bits with `disp_rs` low. It then sends the byte {0, 1, `init_bright`[5:0]} N times with `disp_rs` high (serial mode, 8×N clocks). Only after that does `req_ready` rise. Here N is `n_dev`, with 0 taken as 1.
- R3: `disp_rs` takes its transfer value at least HALF_CYC cycles before `disp_ce_n` falls, and it stays constant while `disp_ce_n` is low. `disp_ce_n` falls only while `disp_clk` is low.
- R4: Each high phase of `disp_clk` inside a transfer lasts exactly HALF_CYC system cycles. Each low phase before a rising edge lasts at least HALF_CYC cycles. At the defaults this is 128 ns per phase and a clock of at most 4 MHz.
- R5: `disp_din` changes only while `disp_clk` is low and stays stable across every rising edge.
- R6: A frame request (`req_kind`=0) makes a transfer with `disp_rs` low and exactly DOTS_PER_DEV×N rising edges. Each edge carries the next stream bit, in arrival order. An `n_dev` of 0 is taken as 1.
- R7: `bit_ready` is high only while `disp_ce_n` is low and the next dot is awaited. When `bit_valid` is low, the serial clock holds low and no edge occurs until a bit arrives.
- R8: A control request (`req_kind`=1) makes a transfer with `disp_rs` high that carries `req_ctrl` MSB first. The byte is repeated N times (8×N edges) when `ctrl_simul`=0, and sent once (8 edges) when `ctrl_simul`=1.
- R9: A transfer ends with `disp_ce_n` rising while `disp_clk` is high. `disp_clk` falls exactly HALF_CYC cycles later, which is the latch. `req_ready` rises exactly 2×HALF_CYC cycles after the `disp_ce_n` rise.
- R10: `req_ready` is low from the accepting cycle until the recovery of R9 ends, so no request is taken during a transfer. `req_kind`, `req_ctrl`, `n_dev` and `ctrl_simul` are sampled only in the accepting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| n_dev | input | DEV_W | Devices in the chain (0 treated as 1) |
| ctrl_simul | input | 1 | Chain is in simultaneous data-out mode for control writes |
| init_bright | input | CTRL_BITS-2 | Brightness field written at start-up |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 1 | 0 = dot frame, 1 = control byte |
| req_ctrl | input | CTRL_BITS | Control byte for a control request |
| bit_valid | input | 1 | Dot stream bit offered |
| bit_ready | output | 1 | Dot stream bit taken when high with bit_valid |
| bit_data | input | 1 | Dot stream bit, 1 = LED on |
| disp_rst_n | output | 1 | Display reset, active low |
| disp_ce_n | output | 1 | Display chip enable, active low |
| disp_rs | output | 1 | Register select, high = control |
| disp_clk | output | 1 | Serial clock |
| disp_din | output | 1 | Serial data |

## Verification
Two things can land in the same cycle: the arrival of a new request, and the tail of a transfer still latching. The bench posts a control request while a frame is in flight and holds it there. The scoreboard then checks that the second transfer starts only after the first one's latch fall and recovery. It also checks that `req_ready` never shows high while chip-enable is low. A second overlap is a stall of the dot stream in the middle of a frame. This is judged by confirming that the serial clock holds low with `bit_ready` high, and that the frame then resumes bit-exact.

// File: rtl/disp_pkg.sv
package disp_pkg;

  typedef enum logic [2:0] {
    E_IDLE, E_RS, E_CEL, E_FETCH, E_LO, E_HI, E_CEH, E_LATCH
  } eng_state_t;

  typedef enum logic [2:0] {
    T_RST, T_GAP, T_INIT_F, T_PRE_C, T_INIT_C, T_IDLE, T_BUSY
  } top_state_t;

  typedef enum logic {
    SRC_FIXED  = 1'b0,
    SRC_STREAM = 1'b1
  } src_t;

  localparam int DOTS_PER_DEV_DEF = 160;
  localparam int CTRL_BITS_DEF    = 8;

endpackage

// File: rtl/disp_tick_gen.sv
module disp_tick_gen #(
  parameter int HALF_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/disp_shift_engine.sv
module disp_shift_engine
  import disp_pkg::*;
#(
  parameter int HALF_CYC  = 16,
  parameter int LEN_W     = 12,
  parameter int CTRL_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 start_rs,
  input  src_t                 start_src,
  input  logic [LEN_W-1:0]     start_len,
  input  logic [CTRL_BITS-1:0] start_byte,
  output logic                 busy,
  output logic                 done,
  input  logic                 bit_valid,
  input  logic                 bit_data,
  output logic                 bit_ready,
  output logic                 disp_ce_n,
  output logic                 disp_rs,
  output logic                 disp_clk,
  output logic                 disp_din
);
  localparam int IDX_W = (CTRL_BITS > 2) ? $clog2(CTRL_BITS) : 1;

  eng_state_t           state_q, state_d;
  src_t                 src_q;
  logic [LEN_W-1:0]     left_q;
  logic [CTRL_BITS-1:0] byte_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 tick, tick_clr, take, next_bit;

  disp_tick_gen #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk (clk),
    .rst (rst),
    .clr (tick_clr),
    .tick(tick)
  );

  assign take      = (state_q == E_FETCH) && ((src_q == SRC_FIXED) || bit_valid);
  assign bit_ready = (state_q == E_FETCH) && (src_q == SRC_STREAM);
  assign next_bit  = (src_q == SRC_STREAM) ? bit_data : byte_q[idx_q];
  assign busy      = (state_q != E_IDLE);
  assign done      = (state_q == E_LATCH) && tick;
  assign tick_clr  = (state_d != state_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      E_IDLE:  if (start) state_d = E_RS;
      E_RS:    if (tick)  state_d = E_CEL;
      E_CEL:   if (tick)  state_d = E_FETCH;
      E_FETCH: if (take)  state_d = E_LO;
      E_LO:    if (tick)  state_d = E_HI;
      E_HI:    if (tick)  state_d = (left_q == LEN_W'(1)) ? E_CEH : E_FETCH;
      E_CEH:   if (tick)  state_d = E_LATCH;
      E_LATCH: if (tick)  state_d = E_IDLE;
      default:            state_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= E_IDLE;
      src_q     <= SRC_FIXED;
      left_q    <= '0;
      byte_q    <= '0;
      idx_q     <= '0;
      disp_ce_n <= 1'b1;
      disp_clk  <= 1'b0;
      disp_rs   <= 1'b0;
      disp_din  <= 1'b0;
    end else begin
      state_q   <= state_d;
      disp_ce_n <= !(state_d inside {E_CEL, E_FETCH, E_LO, E_HI});
      disp_clk  <= (state_d inside {E_HI, E_CEH});
      if ((state_q == E_IDLE) && start) begin
        src_q   <= start_src;
        left_q  <= start_len;
        byte_q  <= start_byte;
        idx_q   <= IDX_W'(CTRL_BITS - 1);
        disp_rs <= start_rs;
      end
      if (take) begin
        disp_din <= next_bit;
        if (src_q == SRC_FIXED)
          idx_q <= (idx_q == '0) ? IDX_W'(CTRL_BITS - 1) : idx_q - 1'b1;
      end
      if ((state_q == E_HI) && tick) left_q <= left_q - 1'b1;
    end
  end

  a_r3_ce_fall_clk_low: assert property (@(posedge clk) disable iff (rst)
    $fell(disp_ce_n) |-> !disp_clk);
  a_r3_rs_held: assert property (@(posedge clk) disable iff (rst)
    (!disp_ce_n && $past(!disp_ce_n)) |-> $stable(disp_rs));
  a_r5_din_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(disp_clk) |-> $stable(disp_din));
  a_r9_ce_rise_clk_high: assert property (@(posedge clk) disable iff (rst)
    $rose(disp_ce_n) |-> disp_clk);
  a_r7_ready_ce_low: assert property (@(posedge clk) disable iff (rst)
    bit_ready |-> !disp_ce_n);
endmodule

// File: rtl/disp_host_ctrl.sv
module disp_host_ctrl
  import disp_pkg::*;
#(
  parameter int HALF_CYC     = 16,
  parameter int RST_CYC      = 8,
  parameter int DEV_W        = 4,
  parameter int DOTS_PER_DEV = DOTS_PER_DEV_DEF,
  parameter int CTRL_BITS    = CTRL_BITS_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DEV_W-1:0]     n_dev,
  input  logic                 ctrl_simul,
  input  logic [CTRL_BITS-3:0] init_bright,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_kind,
  input  logic [CTRL_BITS-1:0] req_ctrl,
  input  logic                 bit_valid,
  output logic                 bit_ready,
  input  logic                 bit_data,
  output logic                 disp_rst_n,
  output logic                 disp_ce_n,
  output logic                 disp_rs,
  output logic                 disp_clk,
  output logic                 disp_din
);
  localparam int MAX_DEV  = (1 << DEV_W) - 1;
  localparam int MAX_BITS = DOTS_PER_DEV * MAX_DEV;
  localparam int LEN_W    = $clog2(MAX_BITS + 1);
  localparam int RC_W     = $clog2(RST_CYC + 1);

  top_state_t           state_q, state_d;
  logic [RC_W-1:0]      rcnt_q;
  logic [DEV_W-1:0]     eff_dev;
  logic [LEN_W-1:0]     frame_len, ctrl_len_ser, ctrl_len;
  logic                 eng_start, eng_rs, eng_busy, eng_done;
  src_t                 eng_src;
  logic [LEN_W-1:0]     eng_len;
  logic [CTRL_BITS-1:0] eng_byte, wake_byte;
  logic                 accept;

  assign eff_dev      = (n_dev == '0) ? DEV_W'(1) : n_dev;
  assign frame_len    = LEN_W'(DOTS_PER_DEV) * LEN_W'(eff_dev);
  assign ctrl_len_ser = LEN_W'(CTRL_BITS) * LEN_W'(eff_dev);
  assign ctrl_len     = ctrl_simul ? LEN_W'(CTRL_BITS) : ctrl_len_ser;
  assign wake_byte    = {1'b0, 1'b1, init_bright};
  assign req_ready    = (state_q == T_IDLE);
  assign accept       = req_ready && req_valid;

  always_comb begin
    state_d   = state_q;
    eng_start = 1'b0;
    eng_rs    = 1'b0;
    eng_src   = SRC_FIXED;
    eng_len   = frame_len;
    eng_byte  = '0;
    unique case (state_q)
      T_RST: if (rcnt_q == RC_W'(RST_CYC)) state_d = T_GAP;
      T_GAP: if (rcnt_q == RC_W'(RST_CYC)) begin
        eng_start = 1'b1;
        state_d   = T_INIT_F;
      end
      T_INIT_F: if (eng_done) state_d = T_PRE_C;
      T_PRE_C: begin
        eng_start = 1'b1;
        eng_rs    = 1'b1;
        eng_len   = ctrl_len_ser;
        eng_byte  = wake_byte;
        state_d   = T_INIT_C;
      end
      T_INIT_C: if (eng_done) state_d = T_IDLE;
      T_IDLE: if (accept) begin
        eng_start = 1'b1;
        eng_rs    = req_kind;
        eng_src   = req_kind ? SRC_FIXED : SRC_STREAM;
        eng_len   = req_kind ? ctrl_len : frame_len;
        eng_byte  = req_ctrl;
        state_d   = T_BUSY;
      end
      T_BUSY: if (eng_done) state_d = T_IDLE;
      default: state_d = T_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= T_RST;
      rcnt_q     <= '0;
      disp_rst_n <= 1'b0;
    end else begin
      state_q    <= state_d;
      disp_rst_n <= (state_d != T_RST);
      if (state_d != state_q)                       rcnt_q <= '0;
      else if (state_q inside {T_RST, T_GAP})       rcnt_q <= rcnt_q + 1'b1;
    end
  end

  disp_shift_engine #(
    .HALF_CYC (HALF_CYC),
    .LEN_W    (LEN_W),
    .CTRL_BITS(CTRL_BITS)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (eng_start),
    .start_rs  (eng_rs),
    .start_src (eng_src),
    .start_len (eng_len),
    .start_byte(eng_byte),
    .busy      (eng_busy),
    .done      (eng_done),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .bit_ready (bit_ready),
    .disp_ce_n (disp_ce_n),
    .disp_rs   (disp_rs),
    .disp_clk  (disp_clk),
    .disp_din  (disp_din)
  );

  a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !eng_busy);
  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
    !disp_rst_n |-> (disp_ce_n && !disp_clk));
  a_r10_start_idle_only: assert property (@(posedge clk) disable iff (rst)
    (accept || eng_start) |-> !eng_busy);
endmodule

// File: tb/test_disp_host_ctrl.sv
module test_disp_host_ctrl;
  localparam int HALF = 16;
  localparam int RSTC = 8;
  localparam int DOTS = 160;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] n_dev = 4'd2;
  logic       ctrl_simul = 1'b0;
  logic [5:0] init_bright = 6'h2B;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_kind = 1'b0;
  logic [7:0] req_ctrl = 8'h00;
  logic       bit_valid = 1'b0;
  logic       bit_ready;
  logic       bit_data = 1'b0;
  logic       disp_rst_n, disp_ce_n, disp_rs, disp_clk, disp_din;

  always #4 clk = ~clk;

  disp_host_ctrl #(.HALF_CYC(HALF), .RST_CYC(RSTC)) i_disp_host_ctrl (
    .clk(clk), .rst(rst), .n_dev(n_dev), .ctrl_simul(ctrl_simul),
    .init_bright(init_bright), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_ctrl(req_ctrl), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .bit_data(bit_data), .disp_rst_n(disp_rst_n),
    .disp_ce_n(disp_ce_n), .disp_rs(disp_rs), .disp_clk(disp_clk),
    .disp_din(disp_din)
  );

  int    checks = 0;
  int    errors = 0;
  bit    exp_bit_q[$];
  int    exp_len_q[$];
  bit    exp_rs_q[$];
  string exp_tag_q[$];
  bit    src_q[$];
  bit    stall = 1'b0;
  bit    take_pend = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // dot stream driver
  always @(negedge clk) begin
    if (take_pend) void'(src_q.pop_front());
    bit_valid = (src_q.size() > 0) && !stall;
    bit_data  = (src_q.size() > 0) ? src_q[0] : 1'b0;
    take_pend = bit_valid && bit_ready;
  end

  // monitor / scoreboard
  bit    p_ce = 1'b1, p_clk = 1'b0, p_rs = 1'b0, p_din = 1'b0, p_ready = 1'b0;
  int    clk_run = 0, rs_run = 0, ce_age = 1000, cur_bits = 0, rise_cnt = 0;
  int    rs_viol = 0, din_viol = 0, rdy_viol = 0, busy_viol = 0;
  bit    rs_at_fall = 1'b0;
  string cur_tag = "R6";

  always @(negedge clk) begin
    if (!rst) begin
      if (p_ce && !disp_ce_n) begin
        cur_bits = 0;
        if (exp_rs_q.size() == 0) chk(1'b0, "R10", "unexpected transfer", 1, 0);
        else begin
          cur_tag = exp_tag_q[0];
          chk(disp_rs == exp_rs_q[0], cur_tag, "select level", disp_rs, exp_rs_q[0]);
        end
        chk(!disp_clk, "R3", "CLK at CE fall", disp_clk, 0);
        chk(rs_run >= HALF, "R3", "select setup cycles", rs_run, HALF);
        rs_at_fall = disp_rs;
      end
      if (!disp_ce_n && disp_rs != rs_at_fall) rs_viol++;
      if (disp_clk != p_clk) begin
        if (disp_clk) begin
          rise_cnt++;
          if (!disp_ce_n) begin
            chk(clk_run >= HALF, "R4", "low phase", clk_run, HALF);
            if (exp_bit_q.size() > 0) begin
              bit b;
              b = exp_bit_q.pop_front();
              chk(disp_din == b, cur_tag, "serial bit", disp_din, b);
            end else chk(1'b0, cur_tag, "surplus edge", 1, 0);
            cur_bits++;
          end
        end else begin
          if (!disp_ce_n) chk(clk_run == HALF, "R4", "high phase", clk_run, HALF);
          else chk(ce_age == HALF, "R9", "CE rise to latch fall", ce_age, HALF);
        end
      end
      if (!disp_ce_n && disp_din != p_din && (disp_clk || p_clk)) din_viol++;
      if (!p_ce && disp_ce_n) begin
        chk(disp_clk, "R9", "CLK at CE rise", disp_clk, 1);
        if (exp_len_q.size() > 0) begin
          chk(cur_bits == exp_len_q[0], cur_tag, "edge count", cur_bits, exp_len_q[0]);
          void'(exp_len_q.pop_front());
          void'(exp_rs_q.pop_front());
          void'(exp_tag_q.pop_front());
        end
      end
      if (req_ready && !p_ready)
        chk(disp_ce_n && ce_age == 2*HALF, "R9", "recovery before ready", ce_age, 2*HALF);
      if (bit_ready && disp_ce_n) rdy_viol++;
      if (req_valid && !disp_ce_n && req_ready) busy_viol++;
      clk_run = (disp_clk != p_clk) ? 1 : clk_run + 1;
      rs_run  = (disp_rs != p_rs) ? 1 : rs_run + 1;
      ce_age  = (!p_ce && disp_ce_n) ? 1 : ce_age + 1;
      p_ce = disp_ce_n; p_clk = disp_clk; p_rs = disp_rs;
      p_din = disp_din; p_ready = req_ready;
    end
  end

  task automatic push_xfer(input bit rs, input int len, input string tag);
    exp_rs_q.push_back(rs);
    exp_len_q.push_back(len);
    exp_tag_q.push_back(tag);
  endtask

  task automatic push_byte(input logic [7:0] b, input int reps);
    for (int r = 0; r < reps; r++)
      for (int i = 7; i >= 0; i--) exp_bit_q.push_back(b[i]);
  endtask

  task automatic issue(input bit kind, input logic [7:0] cbyte);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = kind;
    req_ctrl  = cbyte;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_ctrl  = ~cbyte;  // R10: change after acceptance must not matter
  endtask

  task automatic send_frame(input int ndev, input int seed);
    int eff;
    eff = (ndev == 0) ? 1 : ndev;
    push_xfer(1'b0, DOTS*eff, "R6");
    for (int i = 0; i < DOTS*eff; i++) begin
      bit b;
      b = (((i * 7 + seed) % 5) < 2);
      src_q.push_back(b);
      exp_bit_q.push_back(b);
    end
    n_dev = 4'(ndev);
    issue(1'b0, 8'h00);
  endtask

  task automatic send_ctrl(input int ndev, input bit simul, input logic [7:0] b);
    int eff, reps;
    eff  = (ndev == 0) ? 1 : ndev;
    reps = simul ? 1 : eff;
    push_xfer(1'b1, 8*reps, "R8");
    push_byte(b, reps);
    n_dev = 4'(ndev);
    ctrl_simul = simul;
    issue(1'b1, b);
  endtask

  task automatic wait_ready;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lowc;
    // R2 expected start-up traffic: 2 devices dark, then wake byte 0x6B twice
    push_xfer(1'b0, 2*DOTS, "R2");
    for (int i = 0; i < 2*DOTS; i++) exp_bit_q.push_back(1'b0);
    push_xfer(1'b1, 16, "R2");
    push_byte({2'b01, 6'h2B}, 2);

    repeat (5) @(negedge clk);
    chk(!disp_rst_n, "R1", "reset line in reset", disp_rst_n, 0);
    chk(disp_ce_n && !disp_clk, "R1", "CE/CLK idle in reset", {disp_ce_n, disp_clk}, 2);
    chk(!req_ready && !bit_ready, "R1", "ready low in reset", {req_ready, bit_ready}, 0);
    rst = 1'b0;
    lowc = 0;
    @(negedge clk);
    while (!disp_rst_n) begin
      lowc++;
      if (!disp_ce_n) chk(1'b0, "R1", "CE active during reset pulse", 0, 1);
      @(negedge clk);
    end
    chk(lowc == RSTC, "R1", "reset pulse cycles", lowc, RSTC);

    wait_ready;
    chk(exp_len_q.size() == 0, "R2", "start-up transfers done before ready",
        exp_len_q.size(), 0);

    // frame, one device
    send_frame(1, 3);
    wait_ready;

    // control, serial mode, two devices
    send_ctrl(2, 1'b0, 8'hA5);
    wait_ready;

    // control, simultaneous mode
    send_ctrl(2, 1'b1, 8'h81);
    wait_ready;

    // control, zero devices treated as one
    send_ctrl(0, 1'b0, 8'h3C);
    wait_ready;

    // frame of two devices with a mid-stream stall, plus an overlapping request
    send_frame(2, 11);
    while (src_q.size() > 150) @(negedge clk);
    stall = 1'b1;
    repeat (100) @(negedge clk);
    begin
      int r0;
      r0 = rise_cnt;
      chk(!disp_clk && !disp_ce_n && bit_ready, "R7", "held low awaiting bit",
          {disp_clk, disp_ce_n, bit_ready}, 1);
      repeat (60) @(negedge clk);
      chk(rise_cnt == r0 && !disp_clk, "R7", "no edge during stall", rise_cnt, r0);
    end
    req_valid = 1'b1;
    req_kind  = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R10", "ready while frame busy", req_ready, 0);
    req_valid = 1'b0;
    stall = 1'b0;
    send_ctrl(2, 1'b0, 8'h5A);  // waits behind the frame
    wait_ready;
    repeat (10) @(negedge clk);

    chk(exp_len_q.size() == 0 && exp_bit_q.size() == 0, "R6", "scoreboard drained",
        exp_len_q.size(), 0);
    chk(src_q.size() == 0, "R7", "stream fully consumed", src_q.size(), 0);
    chk(rs_viol == 0, "R3", "select changes with CE low", rs_viol, 0);
    chk(din_viol == 0, "R5", "data changes near high clock", din_viol, 0);
    chk(rdy_viol == 0, "R7", "bit_ready with CE high", rdy_viol, 0);
    chk(busy_viol == 0, "R10", "ready during transfer", busy_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule